// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Prescaler

This block produces the serial clock for an SPI master from a faster module clock. The division runs in two cascaded stages. A pre-stage counts `pre + 1` module clocks and then emits an internal tick. A post-stage counts `post / 2` of those ticks for each half-period of the serial clock. The serial clock frequency is therefore the module clock frequency divided by `post × (pre + 1)`. The low half and the high half of each period have the same length.

The block takes the divisor pair of the slave that is currently addressed. A load strobe copies the pair presented on the inputs into the active settings, and it is accepted only while the prescaler is idle. Raising the enable starts the clock. When the enable is dropped, the block finishes the current period and returns to idle with the clock low. Besides the clock level, the block gives single-cycle tick pulses on each rising and falling edge, which shift logic can use.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: After reset the clock output is low, busy is low, both edge ticks are low, and the active settings are pre = 0 and post = 2, so an enabled run toggles the clock on every module clock.
- R2: While running, each half-period of the clock lasts exactly (pre + 1) × (post / 2) module clocks. The first rising edge comes that many cycles after busy goes high.
- R3: Bit 0 of the post divisor input is ignored, so an odd value acts as the even value just below it.
- R4: A post divisor input of 0 or 1 acts as 2.
- R5: A load strobe while idle makes the presented pair active for the next run. A load strobe while busy is ignored, and the run keeps the pair it started with.
- R6: A change on the divisor inputs without a load strobe has no effect on the clock.
- R7: The rise tick is high for exactly one module clock, in the first cycle the clock is high. The fall tick is high for exactly one module clock, in the first cycle the clock is low after being high. The two are never high together.
- R8: Busy goes high in the cycle after the enable is sampled high while idle. After the enable goes low, busy stays high until the falling edge that ends the current period, and clears in that same cycle.
- R9: While idle the clock is held low and no edge tick occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run request for the serial clock |
| pre_div_i | input | 8 | Pre-stage divisor of the addressed slave, 0 to 255 |
| post_div_i | input | 8 | Post-stage divisor of the addressed slave, even, 2 to 254 |
| load_i | input | 1 | Strobe that copies the divisor pair into the active settings when idle |
| sclk_o | output | 1 | Serial clock level |
| rise_o | output | 1 | One-cycle tick on each rising clock edge |
| fall_o | output | 1 | One-cycle tick on each falling clock edge |
| busy_o | output | 1 | High while the clock is running or finishing its period |

## Verification
The bench covers both ends of the divisor range. With pre 0 and post 2 a half-period is one cycle, and an off-by-one in either stage shows up there as a doubled or stretched clock. With pre 255 and post 254 a half-period is 32512 cycles, which would expose a counter that is too narrow. Odd and zero post values are driven to catch a design that divides by an odd count or stalls at zero. A load is pulsed in the middle of a run, and the divisor inputs are changed without any load, to catch settings that leak in mid-period. Single-cycle and long enable pulses check that a design neither cuts a period short nor leaves busy high after the final falling edge.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int DIV_W  = 8;
    localparam int HALF_W = DIV_W - 1;

    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic [HALF_W-1:0] half;
    } presc_cfg_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_kind_t;

    // Half-period tick count from the post divisor: bit 0 dropped, zero lifted to one.
    function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] post);
        logic [HALF_W-1:0] h;
        h = post[DIV_W-1:1];
        if (h == '0) h = HALF_W'(1);
        return h;
    endfunction

    localparam presc_cfg_t CFG_RESET = '{pre: '0, half: HALF_W'(1)};

endpackage

// File: rtl/spi_presc_cfg.sv
module spi_presc_cfg
    import spi_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] pre_i,
    input  logic [DIV_W-1:0] post_i,
    output presc_cfg_t       cfg_o
);

    presc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load_i && !run_i) begin
            cfg_q <= '{pre: pre_i, half: half_of(post_i)};
        end
    end

    assign cfg_o = cfg_q;

    // R4
    cfg_half_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.half != '0);

    // R5
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |=> $stable(cfg_q));

endmodule

// File: rtl/spi_presc_tick.sv
module spi_presc_tick
    import spi_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] pre_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q == pre_i);
    assign tick_o = run_i && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R2
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= pre_i));

endmodule

// File: rtl/spi_presc_sclk.sv
module spi_presc_sclk
    import spi_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              run_o,
    output logic              sclk_o,
    output logic              rise_o,
    output logic              fall_o
);

    logic [HALF_W-1:0] cnt_q;
    logic              run_q;
    logic              sclk_q;
    edge_kind_t        edge_q;
    logic              flip;

    assign flip = tick_i && (cnt_q == half_i - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            sclk_q <= 1'b0;
            edge_q <= EDGE_NONE;
        end else begin
            edge_q <= EDGE_NONE;
            if (!run_q) begin
                cnt_q <= '0;
                if (en_i) run_q <= 1'b1;
            end else if (tick_i) begin
                if (flip) begin
                    cnt_q  <= '0;
                    sclk_q <= !sclk_q;
                    if (!sclk_q) begin
                        edge_q <= EDGE_RISE;
                    end else begin
                        edge_q <= EDGE_FALL;
                        if (!en_i) run_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + HALF_W'(1);
                end
            end
        end
    end

    assign run_o  = run_q;
    assign sclk_o = sclk_q;
    assign rise_o = (edge_q == EDGE_RISE);
    assign fall_o = (edge_q == EDGE_FALL);

    // R7
    rise_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

    // R7
    fall_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

    // R7
    edges_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise_o && fall_o));

    // R7
    rise_level_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> sclk_o);

    // R7
    fall_level_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |-> !sclk_o);

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run_o |-> !sclk_o);

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && !tick_i) |=> $stable(sclk_o));

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
    import spi_presc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] pre_div_i,
    input  logic [DIV_W-1:0] post_div_i,
    input  logic             load_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             busy_o
);

    presc_cfg_t cfg;
    logic       run;
    logic       tick;

    spi_presc_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .run_i  (run),
        .pre_i  (pre_div_i),
        .post_i (post_div_i),
        .cfg_o  (cfg)
    );

    spi_presc_tick u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .pre_i  (cfg.pre),
        .tick_o (tick)
    );

    spi_presc_sclk u_sclk (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .tick_i (tick),
        .half_i (cfg.half),
        .run_o  (run),
        .sclk_o (sclk_o),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

    assign busy_o = run;

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && en_i) |=> busy_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> fall_o);

endmodule

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [7:0] d_pre = 8'd0;
    logic [7:0] d_post = 8'd2;
    logic       sclk_o, rise_o, fall_o, busy_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #10 clk = !clk;

    spi_sclk_prescaler dut_i (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .pre_div_i  (d_pre),
        .post_div_i (d_post),
        .load_i     (load),
        .sclk_o     (sclk_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o),
        .busy_o     (busy_o)
    );

    // Behavioural reference: one counter over the whole half-period.
    int m_pre, m_half, m_cnt;
    bit m_run, m_sclk, m_rise, m_fall;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_half = 1; m_cnt = 0;
            m_run = 0; m_sclk = 0; m_rise = 0; m_fall = 0;
        end else begin
            m_rise = 0; m_fall = 0;
            if (!m_run) begin
                if (load) begin
                    m_pre  = d_pre;
                    m_half = d_post / 2;
                    if (m_half == 0) m_half = 1;
                end
                if (en) begin
                    m_run = 1;
                    m_cnt = 0;
                end
            end else if (m_cnt == (m_pre + 1) * m_half - 1) begin
                m_cnt  = 0;
                m_sclk = !m_sclk;
                if (m_sclk) m_rise = 1;
                else begin
                    m_fall = 1;
                    if (!en) m_run = 0;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(cur_req, "sclk_o", sclk_o, m_sclk);
            check("R7", "rise_o", rise_o, m_rise);
            check("R7", "fall_o", fall_o, m_fall);
            check("R8", "busy_o", busy_o, m_run);
        end
    end

    task automatic burst(input logic [7:0] p, input logic [7:0] q, input bit do_load, input int ncyc);
        @(negedge clk);
        d_pre = p; d_post = q; load = do_load;
        @(negedge clk);
        load = 1'b0; en = 1'b1;
        repeat (ncyc) @(negedge clk);
        en = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1", "reset sclk_o", sclk_o, 0);
        check("R1", "reset busy_o", busy_o, 0);
        check("R1", "reset rise_o", rise_o, 0);
        check("R1", "reset fall_o", fall_o, 0);
        cur_req = "R1";
        burst(8'd9, 8'd40, 1'b0, 6);

        cur_req = "R2";
        burst(8'd3, 8'd4, 1'b1, 30);
        burst(8'd0, 8'd10, 1'b1, 25);
        burst(8'd5, 8'd2, 1'b1, 20);

        cur_req = "R3";
        burst(8'd2, 8'd7, 1'b1, 40);
        burst(8'd0, 8'd3, 1'b1, 10);

        cur_req = "R4";
        burst(8'd1, 8'd0, 1'b1, 12);
        burst(8'd2, 8'd1, 1'b1, 12);

        cur_req = "R5";
        @(negedge clk);
        d_pre = 8'd0; d_post = 8'd4; load = 1'b1;
        @(negedge clk);
        load = 1'b0; en = 1'b1;
        repeat (5) @(negedge clk);
        d_pre = 8'd9; d_post = 8'd20; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (10) @(negedge clk);
        en = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
        burst(8'd9, 8'd20, 1'b0, 8);
        burst(8'd9, 8'd20, 1'b1, 8);

        cur_req = "R6";
        burst(8'd4, 8'd6, 1'b0, 30);

        cur_req = "R9";
        repeat (4) begin
            @(negedge clk);
            d_pre = d_pre + 8'd3; d_post = d_post + 8'd5;
        end
        repeat (6) @(negedge clk);

        cur_req = "R8";
        burst(8'd2, 8'd4, 1'b1, 1);
        burst(8'd1, 8'd6, 1'b1, 17);

        cur_req = "R2";
        burst(8'd255, 8'd254, 1'b1, 1);

        finish_run();
    end

endmodule